// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block moves one D-PHY data lane of a camera serial transmitter between the low-power stop state and high-speed bursts. Each line of byte data arrives on a valid/ready/last stream. When valid appears while the lane is idle, the block walks the lane through the low-power request states. It then enters high speed, sends a sync byte and the payload, and closes the burst with a trail. After that it returns to the stop state through an exit period. Every timed phase lasts a parameter-set number of byte-clock cycles.

A new line may be offered in the cycle right after the previous last byte. The block keeps that request pending by holding ready low, runs the complete low-power gap, and then takes the new line. The gap length is a fixed number of byte clocks. It does not depend on line length or lane count. A mode input chooses whether the clock lane stays in high speed between bursts or drops to low power. The low-power clock option adds a lead-in phase and a tail phase around every gap. A current-phase output lets the order and length of the phases be observed.

Top module: `dphy_lane_seq`

## Requirements
- R1: While reset is asserted, and whenever the lane is idle, the outputs show the stop state: phase code 0, lp_p_o=1, lp_n_o=1, hs_en_o=0, s_ready_o=0 and hs_data_o=0. clk_hs_o is 0 during reset.
- R2: When valid is seen in the stop state, the lane enters the request phase (code 2, lp_p_o=0, lp_n_o=1) for T_LPX cycles. It then enters the bridge phase (code 3, both lines low) for T_LPX cycles and the prepare phase (code 4, both lines low, HS off) for T_PREP cycles. Next comes one sync cycle (code 5, hs_en_o=1) with hs_data_o=8'hB8. In every HS phase both LP lines are low.
- R3: The request and bridge phases each last at least ceil(50000 / BYTE_CLK_PS) cycles. A smaller T_LPX is raised to that minimum.
- R4: s_ready_o is high in the sync cycle and in the data phase (code 6) until the byte marked last has been taken. Each taken byte appears on hs_data_o one cycle later, in order, with hs_en_o=1.
- R5: After the cycle carrying the last byte, the trail phase (code 7, hs_en_o=1) lasts T_TRAIL cycles. In that phase hs_data_o holds all bits equal to the inverse of bit 7 of the last byte, which is the last bit sent on the wire.
- R6: After the trail, the exit phase (code 8, LP-11, HS off, hs_data_o=0) lasts T_EXIT cycles. The lane then returns to the stop state for at least one cycle. In low-power clock mode it first passes through the clock tail phase.
- R7: When valid stays high right after a last byte, the new line is held back by s_ready_o=0. The number of cycles between the last data cycle and the next sync cycle is T_TRAIL+T_EXIT+1+2*T_LPX+T_PREP for any line length.
- R8: With cont_clk_i=1, clk_hs_o is high from the cycle after enable, including in the stop state. With cont_clk_i=0, clk_hs_o is low in the stop state. In that mode a clock lead-in phase (code 1, LP-11) of T_CKPRE cycles precedes the request phase, and a clock tail phase (code 9, LP-11) of T_CKPOST cycles follows the exit phase. Together they add T_CKPRE+T_CKPOST cycles to the gap.
- R9: If en_i is low at a clock edge, the next cycle shows the stop state with hs_data_o=0 and clk_hs_o=0, whatever the current phase. Valid is ignored while en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Lane enable; low forces the stop state |
| cont_clk_i | input | 1 | 1: clock lane stays in HS between bursts |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Marks the final byte of a line |
| s_ready_o | output | 1 | Byte taken when high together with valid |
| hs_data_o | output | 8 | High-speed byte to the serializer |
| hs_en_o | output | 1 | High-speed driver enable |
| lp_p_o | output | 1 | Low-power level, positive line |
| lp_n_o | output | 1 | Low-power level, negative line |
| clk_hs_o | output | 1 | Clock lane high-speed enable |
| phase_o | output | 4 | Current phase code |

## Verification
A behavioural model builds the expected per-cycle schedule for each line from its bytes and the clock mode. The block is driven with isolated lines, with back-to-back lines of very different lengths, and with single-byte lines. Isolated lines check the entry and exit order. Back-to-back lines show that the gap stays constant while a new request waits, and single-byte lines test taking last in the sync cycle. Each pattern runs in both clock modes to separate the extra clock phases from the data-lane phases. Disable is applied during entry and during trail, and valid is held with the lane disabled, to show the forced return to stop. A second instance with a too-small request length checks the 50 ns floor.

// File: rtl/dphy_lane_pkg.sv
package dphy_lane_pkg;

    localparam int BYTE_W = 8;
    localparam int PH_W   = 4;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;
    localparam int LP_STATE_MIN_PS = 50000;

    typedef enum logic [PH_W-1:0] {
        PH_STOP   = 4'd0,
        PH_CKPRE  = 4'd1,
        PH_REQ    = 4'd2,
        PH_BRIDGE = 4'd3,
        PH_PREP   = 4'd4,
        PH_SYNC   = 4'd5,
        PH_DATA   = 4'd6,
        PH_TRAIL  = 4'd7,
        PH_EXIT   = 4'd8,
        PH_CKPOST = 4'd9
    } phase_e;

    function automatic int min_lp_cycles(input int clk_ps);
        return (LP_STATE_MIN_PS + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/dphy_phase_len.sv
module dphy_phase_len
    import dphy_lane_pkg::*;
#(
    parameter int CW       = 6,
    parameter int N_LPX    = 7,
    parameter int N_PREP   = 4,
    parameter int N_TRAIL  = 5,
    parameter int N_EXIT   = 6,
    parameter int N_CKPRE  = 3,
    parameter int N_CKPOST = 4
) (
    input  phase_e          phase_i,
    output logic [CW-1:0]   len_o
);

    always_comb begin
        unique case (phase_i)
            PH_CKPRE:            len_o = CW'(N_CKPRE);
            PH_REQ, PH_BRIDGE:   len_o = CW'(N_LPX);
            PH_PREP:             len_o = CW'(N_PREP);
            PH_TRAIL:            len_o = CW'(N_TRAIL);
            PH_EXIT:             len_o = CW'(N_EXIT);
            PH_CKPOST:           len_o = CW'(N_CKPOST);
            default:             len_o = CW'(1);
        endcase
    end

endmodule

// File: rtl/dphy_line_drive.sv
module dphy_line_drive
    import dphy_lane_pkg::*;
(
    input  phase_e phase_i,
    output logic   lp_p_o,
    output logic   lp_n_o,
    output logic   hs_en_o
);

    always_comb begin
        lp_p_o  = 1'b0;
        lp_n_o  = 1'b0;
        hs_en_o = 1'b0;
        unique case (phase_i)
            PH_STOP, PH_CKPRE, PH_EXIT, PH_CKPOST: begin
                lp_p_o = 1'b1;
                lp_n_o = 1'b1;
            end
            PH_REQ: begin
                lp_n_o = 1'b1;
            end
            PH_SYNC, PH_DATA, PH_TRAIL: begin
                hs_en_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
    import dphy_lane_pkg::*;
#(
    parameter int BYTE_CLK_PS = 8000,
    parameter int T_LPX       = 7,
    parameter int T_PREP      = 4,
    parameter int T_TRAIL     = 5,
    parameter int T_EXIT      = 6,
    parameter int T_CKPRE     = 3,
    parameter int T_CKPOST    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cont_clk_i,
    input  logic              s_valid_i,
    input  logic [BYTE_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic [BYTE_W-1:0] hs_data_o,
    output logic              hs_en_o,
    output logic              lp_p_o,
    output logic              lp_n_o,
    output logic              clk_hs_o,
    output logic [PH_W-1:0]   phase_o
);

    localparam int MIN_LPX = min_lp_cycles(BYTE_CLK_PS);
    localparam int LPX_EFF = (T_LPX < MIN_LPX) ? MIN_LPX : T_LPX;
    localparam int SPAN    = LPX_EFF + T_PREP + T_TRAIL + T_EXIT + T_CKPRE + T_CKPOST;
    localparam int CW      = $clog2(SPAN + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] data;
        logic              fin;
        logic              clk_hs;
    } seq_st_t;

    seq_st_t        st_q, st_d;
    phase_e         nxt;
    logic [CW-1:0]  len;
    logic           done;
    logic           take;

    dphy_phase_len #(
        .CW       (CW),
        .N_LPX    (LPX_EFF),
        .N_PREP   (T_PREP),
        .N_TRAIL  (T_TRAIL),
        .N_EXIT   (T_EXIT),
        .N_CKPRE  (T_CKPRE),
        .N_CKPOST (T_CKPOST)
    ) u_len (
        .phase_i (st_q.phase),
        .len_o   (len)
    );

    dphy_line_drive u_drive (
        .phase_i (st_q.phase),
        .lp_p_o  (lp_p_o),
        .lp_n_o  (lp_n_o),
        .hs_en_o (hs_en_o)
    );

    assign done      = (st_q.cnt == len - CW'(1));
    assign s_ready_o = en_i && ((st_q.phase == PH_SYNC) ||
                                (st_q.phase == PH_DATA && !st_q.fin));
    assign take      = s_valid_i && s_ready_o;

    always_comb begin
        st_d = st_q;
        nxt  = st_q.phase;
        unique case (st_q.phase)
            PH_STOP:   if (s_valid_i) nxt = cont_clk_i ? PH_REQ : PH_CKPRE;
            PH_CKPRE:  if (done) nxt = PH_REQ;
            PH_REQ:    if (done) nxt = PH_BRIDGE;
            PH_BRIDGE: if (done) nxt = PH_PREP;
            PH_PREP: begin
                if (done) begin
                    nxt       = PH_SYNC;
                    st_d.data = SYNC_BYTE;
                end
            end
            PH_SYNC: begin
                nxt = PH_DATA;
                if (take) begin
                    st_d.data = s_data_i;
                    st_d.fin  = s_last_i;
                end
            end
            PH_DATA: begin
                if (st_q.fin) begin
                    nxt       = PH_TRAIL;
                    st_d.data = {BYTE_W{~st_q.data[BYTE_W-1]}};
                    st_d.fin  = 1'b0;
                end else if (take) begin
                    st_d.data = s_data_i;
                    st_d.fin  = s_last_i;
                end
            end
            PH_TRAIL: begin
                if (done) begin
                    nxt       = PH_EXIT;
                    st_d.data = '0;
                end
            end
            PH_EXIT:   if (done) nxt = cont_clk_i ? PH_STOP : PH_CKPOST;
            PH_CKPOST: if (done) nxt = PH_STOP;
            default:   nxt = PH_STOP;
        endcase
        st_d.phase  = nxt;
        st_d.cnt    = (nxt != st_q.phase) ? '0 : st_q.cnt + CW'(1);
        st_d.clk_hs = cont_clk_i || (nxt != PH_STOP);
        if (!en_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_data_o = st_q.data;
    assign clk_hs_o  = st_q.clk_hs;
    assign phase_o   = st_q.phase;

endmodule

// File: rtl/dphy_lane_seq_chk.sv
module dphy_lane_seq_chk
    import dphy_lane_pkg::*;
#(
    parameter int BYTE_CLK_PS = 8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              cont_clk_i,
    input logic              s_ready_o,
    input logic [BYTE_W-1:0] hs_data_o,
    input logic              hs_en_o,
    input logic              clk_hs_o,
    input logic [PH_W-1:0]   phase_o
);

    localparam int MIN_LPX = min_lp_cycles(BYTE_CLK_PS);

    logic [15:0] req_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_run_q <= '0;
        end else if (phase_o == PH_REQ) begin
            req_run_q <= (req_run_q == 16'hFFFF) ? req_run_q : req_run_q + 16'd1;
        end else begin
            req_run_q <= '0;
        end
    end

    AST_REQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_REQ && $past(phase_o) != PH_REQ) |->
        ($past(phase_o) == PH_STOP || $past(phase_o) == PH_CKPRE)); // R2

    AST_SYNC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_SYNC) |-> (hs_data_o == SYNC_BYTE)); // R2

    AST_LPX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_o) == PH_REQ && phase_o != PH_REQ && $past(en_i)) |->
        (req_run_q >= 16'(MIN_LPX))); // R3

    AST_READY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> hs_en_o); // R4

    AST_TRAIL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_TRAIL && $past(phase_o) == PH_DATA) |->
        (hs_data_o == {BYTE_W{~$past(hs_data_o[BYTE_W-1])}})); // R5

    AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_TRAIL && $past(phase_o) == PH_TRAIL) |-> $stable(hs_data_o)); // R5

    AST_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_o) == PH_EXIT && phase_o != PH_EXIT && $past(en_i)) |->
        (phase_o == PH_STOP || phase_o == PH_CKPOST)); // R6

    AST_CONT_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_clk_i && en_i) |=> clk_hs_o); // R8

    AST_NONCONT_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cont_clk_i) && phase_o == PH_STOP) |-> !clk_hs_o); // R8

    AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (phase_o == PH_STOP && !clk_hs_o && hs_data_o == '0)); // R9

endmodule

bind dphy_lane_seq dphy_lane_seq_chk #(.BYTE_CLK_PS(BYTE_CLK_PS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .cont_clk_i (cont_clk_i),
    .s_ready_o  (s_ready_o),
    .hs_data_o  (hs_data_o),
    .hs_en_o    (hs_en_o),
    .clk_hs_o   (clk_hs_o),
    .phase_o    (phase_o)
);

// File: tb/tb_dphy_lane_seq.sv
`timescale 1ns/1ps
module tb_dphy_lane_seq;

    localparam int LPX = 9, PREP = 4, TRAIL = 5, EXIT = 6, CKPRE = 3, CKPOST = 4;
    localparam int CLK_PS = 8000;
    localparam int MIN_LP = (50000 + CLK_PS - 1) / CLK_PS;
    localparam int GAP_CONT = TRAIL + EXIT + 1 + 2 * LPX + PREP;
    localparam int GAP_NONC = GAP_CONT + CKPRE + CKPOST;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cont = 1'b1;
    logic valid = 1'b0, last = 1'b0;
    logic [7:0] data = 8'h00;
    logic ready, hs_en, lp_p, lp_n, clk_hs;
    logic [7:0] hs_data;
    logic [3:0] phase;
    logic ready2, hs_en2, lp_p2, lp_n2, clk_hs2;
    logic [7:0] hs_data2;
    logic [3:0] phase2;

    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    dphy_lane_seq #(.BYTE_CLK_PS(CLK_PS), .T_LPX(LPX), .T_PREP(PREP), .T_TRAIL(TRAIL),
        .T_EXIT(EXIT), .T_CKPRE(CKPRE), .T_CKPOST(CKPOST)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cont_clk_i(cont), .s_valid_i(valid),
        .s_data_i(data), .s_last_i(last), .s_ready_o(ready), .hs_data_o(hs_data),
        .hs_en_o(hs_en), .lp_p_o(lp_p), .lp_n_o(lp_n), .clk_hs_o(clk_hs), .phase_o(phase));

    dphy_lane_seq #(.BYTE_CLK_PS(CLK_PS), .T_LPX(2), .T_PREP(PREP), .T_TRAIL(TRAIL),
        .T_EXIT(EXIT), .T_CKPRE(CKPRE), .T_CKPOST(CKPOST)) dut_floor (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1), .cont_clk_i(1'b1), .s_valid_i(1'b1),
        .s_data_i(8'h5A), .s_last_i(1'b1), .s_ready_o(ready2), .hs_data_o(hs_data2),
        .hs_en_o(hs_en2), .lp_p_o(lp_p2), .lp_n_o(lp_n2), .clk_hs_o(clk_hs2), .phase_o(phase2));

    typedef struct packed {
        logic [3:0] ph;
        logic       p;
        logic       n;
        logic       hsen;
        logic       rdy;
        logic [7:0] d;
    } rec_t;

    rec_t exp_q[$];
    int   len_q[$];
    logic [7:0] byte_q[$];
    logic en_smp = 1'b0, cont_smp = 1'b0;

    function automatic rec_t mk(input int ph, input logic [7:0] d, input logic rdy);
        rec_t r;
        r.ph   = 4'(ph);
        r.p    = (ph == 0 || ph == 1 || ph == 8 || ph == 9);
        r.n    = r.p || (ph == 2);
        r.hsen = (ph == 5 || ph == 6 || ph == 7);
        r.rdy  = rdy;
        r.d    = d;
        return r;
    endfunction

    function automatic string tag_of(input int ph);
        case (ph)
            0:       return "R1";
            1, 9:    return "R8";
            2, 3, 4, 5: return "R2";
            6:       return "R4";
            7:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [7:0] byte_at(input int base, input int i);
        return 8'((base + i * 53) & 255);
    endfunction

    // cycle model: expected outputs for every cycle
    always @(negedge clk) begin
        rec_t e;
        rec_t act;
        logic cexp;
        if (!rst_n) begin
            exp_q.delete();
            en_smp   = 1'b0;
            cont_smp = 1'b0;
        end else begin
            e = (exp_q.size() != 0) ? exp_q.pop_front() : mk(0, 8'h00, 1'b0);
            e.rdy = e.rdy && en;
            cexp = en_smp && (cont_smp || e.ph != 4'd0);
            act = '{ph: phase, p: lp_p, n: lp_n, hsen: hs_en, rdy: ready, d: hs_data};
            if (act != e)
                check(1'b0, tag_of(int'(e.ph)), int'(act), int'(e));
            else
                check(clk_hs === cexp, "R8", int'(clk_hs), int'(cexp));
            if (!en) begin
                exp_q.delete();
                len_q.delete();
                byte_q.delete();
            end else if (exp_q.size() == 0 && e.ph == 4'd0 && valid && len_q.size() != 0) begin
                int n;
                logic [7:0] b;
                n = len_q.pop_front();
                if (!cont) for (int k = 0; k < CKPRE; k++) exp_q.push_back(mk(1, 8'h00, 1'b0));
                for (int k = 0; k < LPX; k++) exp_q.push_back(mk(2, 8'h00, 1'b0));
                for (int k = 0; k < LPX; k++) exp_q.push_back(mk(3, 8'h00, 1'b0));
                for (int k = 0; k < PREP; k++) exp_q.push_back(mk(4, 8'h00, 1'b0));
                exp_q.push_back(mk(5, 8'hB8, 1'b1));
                b = 8'h00;
                for (int k = 0; k < n; k++) begin
                    b = byte_q.pop_front();
                    exp_q.push_back(mk(6, b, k < n - 1));
                end
                for (int k = 0; k < TRAIL; k++) exp_q.push_back(mk(7, {8{~b[7]}}, 1'b0));
                for (int k = 0; k < EXIT; k++) exp_q.push_back(mk(8, 8'h00, 1'b0));
                if (!cont) for (int k = 0; k < CKPOST; k++) exp_q.push_back(mk(9, 8'h00, 1'b0));
                exp_q.push_back(mk(0, 8'h00, 1'b0));
            end
            en_smp   = en;
            cont_smp = cont;
        end
    end

    // gap measurement between consecutive bursts
    bit in_gap = 1'b0;
    int gap_cnt = 0, last_gap = -1;
    int run2 = 0, floor_len = -1;
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            in_gap = 1'b0;
        end else if (phase == 4'd6) begin
            in_gap = 1'b1;
            gap_cnt = 0;
        end else if (phase == 4'd5 && in_gap) begin
            last_gap = gap_cnt;
            in_gap = 1'b0;
        end else if (in_gap) begin
            gap_cnt++;
        end
        if (rst_n && phase2 == 4'd2) run2++;
        else begin
            if (run2 != 0 && floor_len < 0) floor_len = run2;
            run2 = 0;
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 20000);
            summary_and_end();
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drive_line(input int n, input int base);
        int i;
        bit acc;
        len_q.push_back(n);
        for (int k = 0; k < n; k++) byte_q.push_back(byte_at(base, k));
        i = 0;
        while (i < n) begin
            valid = 1'b1;
            data  = byte_at(base, i);
            last  = (i == n - 1);
            @(negedge clk);
            acc = ready;
            @(posedge clk);
            #1;
            if (acc) i++;
        end
    endtask

    task automatic idle();
        valid = 1'b0;
        last  = 1'b0;
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while (phase != 4'(p));
        @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        @(negedge clk);
        // R1: reset state
        check(phase == 4'd0 && lp_p && lp_n && !hs_en && !ready && hs_data == 8'h00 && !clk_hs,
              "R1", int'({phase, lp_p, lp_n, hs_en, ready, clk_hs}), int'({4'd0, 5'b11000}));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        en    = 1'b1;
        cont  = 1'b1;
        step(5);

        // R2 R4 R5 R6: isolated line, continuous clock
        drive_line(4, 8'h10);
        idle();
        step(60);

        // R7: back-to-back lines of different lengths
        drive_line(3, 8'h80);
        drive_line(20, 8'h21);
        check(last_gap == GAP_CONT, "R7", last_gap, GAP_CONT);
        drive_line(1, 8'hF0);
        check(last_gap == GAP_CONT, "R7", last_gap, GAP_CONT);
        idle();
        step(60);

        // R8: low-power clock mode adds lead-in and tail phases
        cont = 1'b0;
        step(5);
        drive_line(5, 8'h33);
        drive_line(2, 8'hC4);
        check(last_gap == GAP_NONC, "R8", last_gap, GAP_NONC);
        drive_line(30, 8'h07);
        check(last_gap == GAP_NONC, "R7", last_gap, GAP_NONC);
        idle();
        step(70);
        drive_line(1, 8'h01);
        idle();
        step(70);

        // R9: valid ignored while disabled
        cont  = 1'b1;
        en    = 1'b0;
        valid = 1'b1;
        data  = 8'hAA;
        step(15);
        check(phase == 4'd0 && !ready, "R9", int'(phase), 0);
        valid = 1'b0;
        en    = 1'b1;
        step(5);

        // R9: disable during the bridge phase
        len_q.push_back(4);
        for (int k = 0; k < 4; k++) byte_q.push_back(byte_at(8'h44, k));
        valid = 1'b1;
        data  = byte_at(8'h44, 0);
        last  = 1'b0;
        wait_phase(3);
        en = 1'b0;
        idle();
        step(1);
        @(negedge clk);
        check(phase == 4'd0 && !clk_hs && hs_data == 8'h00, "R9", int'(phase), 0);
        @(posedge clk);
        #1;
        en = 1'b1;
        step(4);

        // R9: disable during the trail
        drive_line(6, 8'h99);
        idle();
        wait_phase(7);
        en = 1'b0;
        step(1);
        @(negedge clk);
        check(phase == 4'd0 && hs_data == 8'h00, "R9", int'(hs_data), 0);
        @(posedge clk);
        #1;
        en = 1'b1;
        step(5);

        // R2 R4: a final line after recovery
        drive_line(8, 8'h5C);
        idle();
        step(60);

        // R3: floor on request length
        check(floor_len == MIN_LP, "R3", floor_len, MIN_LP);

        summary_and_end();
    end

endmodule